// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter

This block turns an unpacked floating-point operand into a two's-complement integer of `OUT_W` bits (32 by default). The operand arrives already split into a class code, a sign bit, a signed unbiased exponent and a mantissa whose most significant bit is the explicit leading one. The value of a number is `mant × 2^(exp − (MANT_W − 1))`. The conversion always truncates toward zero and ignores any rounding mode.

Besides the integer, the block reports two flags. The inexact flag is raised when fraction bits are discarded. The invalid flag is raised when the operand cannot be represented, and in that case the output saturates according to the sign. The block is a single registered stage. An operand presented with `in_valid` high appears on the outputs one clock later with `out_valid` high. Operands presented with `in_valid` low leave the outputs unchanged.

Top module: `fp2int_conv`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. The outputs `out_result`, `out_inexact` and `out_invalid` change only in a cycle that follows an accepted operand.
- R2: Class code 0 (zero) produces result 0 with both flags clear, whatever the sign.
- R3: For class code 1 (number) in range, the result is the integer part of the magnitude, truncated toward zero. It is negated in two's complement when the sign is 1.
- R4: For an in-range number, inexact is 1 exactly when any mantissa bit below the integer point is 1. Invalid is 0.
- R5: A number with a negative exponent yields 0, with inexact equal to the OR of all mantissa bits.
- R6: A number with exponent `OUT_W` (32) or larger always takes the overflow path.
- R7: The magnitude limit is 2^31 for a negative sign and 2^31−1 for a positive sign. A truncated magnitude above the limit for its sign takes the overflow path, and −2^31 converts without overflow.
- R8: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 all take the overflow path.
- R9: On the overflow path the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. Invalid is 1 and inexact is 0, even if fraction bits were dropped.
- R10: After reset, `out_valid`, `out_result`, `out_inexact` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Operand class code (0 zero, 1 number, 2 inf, 3 qNaN, 4 sNaN) |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa with explicit leading one at the MSB |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| out_result | output | OUT_W | Two's-complement integer |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand not representable, result saturated |

## Verification
A mis-aligned shift shows up one cycle after the operand as an integer off by a power of two, or as a missing inexact flag on values with fractional parts. An off-by-one in the limit comparison is only visible at the ±2^31 boundary. For that reason, operands sitting exactly on, just above and just below each signed limit are applied. A flag or saturation error on the overflow path appears as a wrong sign of the saturated value, or as inexact left set together with invalid, in the very next result.

// File: rtl/fp2i_pkg.sv
// Shared definitions for the float-to-integer converter.
// Assumes class codes are produced by an upstream unpacker using this encoding.
package fp2i_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

endpackage

// File: rtl/fp2i_align.sv
// Aligns the mantissa so the integer part lands in the low OUT_W bits, and ORs
// every discarded bit into a sticky flag. Flags exponents too large for OUT_W.
// Assumes MANT_W >= OUT_W and the leading one sits at the mantissa MSB.
module fp2i_align #(
    parameter int OUT_W  = 32,
    parameter int MANT_W = 64,
    parameter int EXP_W  = 16
) (
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [OUT_W-1:0]  mag,
    output logic              sticky,
    output logic              exp_big
);
    localparam int SH_W = $clog2(MANT_W) + 1;
    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);
    localparam logic [SH_W-1:0]  TOP_POS = SH_W'(MANT_W - 1);

    logic              exp_neg;
    logic [SH_W-1:0]   sh_amt;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] lost_mask;

    // Compute shift distance, shifted mantissa and the mask of lost bits.
    always_comb begin
        exp_neg   = exp_in[EXP_W-1];
        exp_big   = !exp_neg && (exp_in >= EXP_LIM);
        sh_amt    = TOP_POS - SH_W'(exp_in);
        shifted   = mant >> sh_amt;
        lost_mask = ~({MANT_W{1'b1}} << sh_amt);
    end

    // Select magnitude and sticky for the three exponent ranges.
    always_comb begin
        if (exp_neg) begin
            mag    = '0;
            sticky = |mant;
        end else if (exp_big) begin
            mag    = '0;
            sticky = 1'b0;
        end else begin
            mag    = shifted[OUT_W-1:0];
            sticky = |(mant & lost_mask);
        end
    end

endmodule

// File: rtl/fp2i_saturate.sv
// Applies the sign-dependent range limit, negates in-range magnitudes and
// produces the flags. On overflow the result is the limit itself and invalid
// replaces inexact.
module fp2i_saturate
    import fp2i_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  fp_class_e         cls,
    input  logic              sign,
    input  logic              exp_big,
    input  logic [OUT_W-1:0]  mag,
    input  logic              sticky,
    output logic [OUT_W-1:0]  result,
    output logic              inexact,
    output logic              invalid
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

    logic [OUT_W-1:0] limit;
    logic             ovf;

    // Decide the limit for this sign and whether the operand exceeds it.
    always_comb begin
        limit = POS_MAX + OUT_W'(sign);
        ovf   = (cls != CLS_ZERO) &&
                ((cls != CLS_NUM) || exp_big || (mag > limit));
    end

    // Pick zero, saturated or signed in-range result with its flags.
    always_comb begin
        if (cls == CLS_ZERO) begin
            result  = '0;
            inexact = 1'b0;
            invalid = 1'b0;
        end else if (ovf) begin
            result  = limit;
            inexact = 1'b0;
            invalid = 1'b1;
        end else begin
            result  = sign ? (~mag + OUT_W'(1)) : mag;
            inexact = sticky;
            invalid = 1'b0;
        end
    end

endmodule

// File: rtl/fp2int_conv.sv
// Float-to-signed-integer converter, one registered stage.
// Truncates toward zero; saturates by sign with invalid on overflow.
// Assumes an unpacked operand whose mantissa carries an explicit leading one.
module fp2int_conv
    import fp2i_pkg::*;
#(
    parameter int OUT_W  = 32,
    parameter int MANT_W = 64,
    parameter int EXP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_result,
    output logic              out_inexact,
    output logic              out_invalid
);
    logic [OUT_W-1:0] mag;
    logic             sticky;
    logic             exp_big;
    logic [OUT_W-1:0] nxt_result;
    logic             nxt_inexact;
    logic             nxt_invalid;
    fp_class_e        cls;

    // Interpret the raw class bits as the shared enumeration.
    always_comb cls = fp_class_e'(in_class);

    fp2i_align #(.OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .mant    (in_mant),
        .exp_in  (in_exp),
        .mag     (mag),
        .sticky  (sticky),
        .exp_big (exp_big)
    );

    fp2i_saturate #(.OUT_W(OUT_W)) u_sat (
        .cls     (cls),
        .sign    (in_sign),
        .exp_big (exp_big),
        .mag     (mag),
        .sticky  (sticky),
        .result  (nxt_result),
        .inexact (nxt_inexact),
        .invalid (nxt_invalid)
    );

    // Register valid every cycle; capture results only for accepted operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt_result;
                out_inexact <= nxt_inexact;
                out_invalid <= nxt_invalid;
            end
        end
    end

endmodule

// File: rtl/fp2int_conv_chk.sv
// Temporal checks on the converter's ports, attached by bind.
module fp2int_conv_chk #(
    parameter int OUT_W = 32,
    parameter int EXP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic             in_sign,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_result,
    input logic             out_inexact,
    input logic             out_invalid
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));
    // R2
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd0) |=>
            (out_result == '0 && !out_inexact && !out_invalid));
    // R8
    special_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class >= 3'd2) |=>
            (out_invalid && out_result == ($past(in_sign) ? NEG_MIN : POS_MAX)));
    // R9
    no_overflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_inexact);
    // R9
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_result == POS_MAX || out_result == NEG_MIN));

endmodule

bind fp2int_conv fp2int_conv_chk #(.OUT_W(OUT_W), .EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_sign     (in_sign),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/fp2int_conv_bench.sv
`timescale 1ns/1ps
// Directed bench for the float-to-integer converter.
module fp2int_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_class = 3'd0;
    logic        in_sign = 1'b0;
    logic [15:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_inexact;
    logic        out_invalid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fp2int_conv u_fp2int_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    task automatic check(string req, logic [31:0] r, logic nx, logic nv, logic v);
        n_vec++;
        if (out_result !== r || out_inexact !== nx || out_invalid !== nv || out_valid !== v) begin
            n_bad++;
            $display("FAIL %s: got res=%h nx=%b nv=%b v=%b, expected res=%h nx=%b nv=%b v=%b",
                     req, out_result, out_inexact, out_invalid, out_valid, r, nx, nv, v);
        end
    endtask

    // Present one operand for one cycle and check it one cycle later.
    task automatic apply(string req, logic [2:0] c, logic s, logic signed [15:0] e,
                         logic [63:0] m, logic [31:0] r, logic nx, logic nv);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = e; in_mant = m;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, r, nx, nv, 1'b1);
    endtask

    task automatic t_reset();
        check("R10 reset", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero();
        apply("R2 +zero", 3'd0, 1'b0, 16'sd5, 64'hFFFF_0000_0000_0000, 32'h0, 0, 0);
        apply("R2 -zero", 3'd0, 1'b1, -16'sd3, 64'h8000_0000_0000_0001, 32'h0, 0, 0);
    endtask

    task automatic t_truncate();
        apply("R3 one",      3'd1, 1'b0, 16'sd0, 64'h8000_0000_0000_0000, 32'h1, 0, 0);
        apply("R3 R4 -1.5",  3'd1, 1'b1, 16'sd0, 64'hC000_0000_0000_0000, 32'hFFFF_FFFF, 1, 0);
        apply("R3 R4 3.75",  3'd1, 1'b0, 16'sd1, 64'hF000_0000_0000_0000, 32'h3, 1, 0);
        apply("R3 R4 -3.75", 3'd1, 1'b1, 16'sd1, 64'hF000_0000_0000_0000, 32'hFFFF_FFFD, 1, 0);
        apply("R4 max exact",3'd1, 1'b0, 16'sd30, 64'hFFFF_FFFE_0000_0000, 32'h7FFF_FFFF, 0, 0);
        apply("R4 max frac", 3'd1, 1'b0, 16'sd30, 64'hFFFF_FFFF_0000_0000, 32'h7FFF_FFFF, 1, 0);
        apply("R4 lsb sticky", 3'd1, 1'b0, 16'sd5, 64'h8000_0000_0000_0001, 32'h20, 1, 0);
    endtask

    task automatic t_small();
        apply("R5 0.75",   3'd1, 1'b0, -16'sd1,   64'hC000_0000_0000_0000, 32'h0, 1, 0);
        apply("R5 -0.75",  3'd1, 1'b1, -16'sd1,   64'hC000_0000_0000_0000, 32'h0, 1, 0);
        apply("R5 tiny",   3'd1, 1'b1, -16'sd100, 64'h8000_0000_0000_0000, 32'h0, 1, 0);
    endtask

    task automatic t_limits();
        apply("R7 -2^31 exact", 3'd1, 1'b1, 16'sd31, 64'h8000_0000_0000_0000, 32'h8000_0000, 0, 0);
        apply("R7 -2^31 frac",  3'd1, 1'b1, 16'sd31, 64'h8000_0000_8000_0000, 32'h8000_0000, 1, 0);
        apply("R7 +2^31",       3'd1, 1'b0, 16'sd31, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 0, 1);
        apply("R7 -2^31-1",     3'd1, 1'b1, 16'sd31, 64'h8000_0001_0000_0000, 32'h8000_0000, 0, 1);
        apply("R9 +ovf drops inexact", 3'd1, 1'b0, 16'sd31, 64'h8000_0000_8000_0000, 32'h7FFF_FFFF, 0, 1);
    endtask

    task automatic t_big_exp();
        apply("R6 exp32 neg",  3'd1, 1'b1, 16'sd32,   64'h8000_0000_0000_0000, 32'h8000_0000, 0, 1);
        apply("R6 exp1000",    3'd1, 1'b0, 16'sd1000, 64'hC000_0000_0000_0000, 32'h7FFF_FFFF, 0, 1);
    endtask

    task automatic t_special();
        apply("R8 +inf",  3'd2, 1'b0, 16'sd0, 64'h0, 32'h7FFF_FFFF, 0, 1);
        apply("R8 -inf",  3'd2, 1'b1, 16'sd0, 64'h0, 32'h8000_0000, 0, 1);
        apply("R8 -qnan", 3'd3, 1'b1, 16'sd0, 64'hC000_0000_0000_0000, 32'h8000_0000, 0, 1);
        apply("R8 +snan", 3'd4, 1'b0, 16'sd0, 64'hA000_0000_0000_0000, 32'h7FFF_FFFF, 0, 1);
        apply("R8 code7", 3'd7, 1'b1, 16'sd0, 64'h8000_0000_0000_0000, 32'h8000_0000, 0, 1);
    endtask

    // Inputs changing without in_valid must not disturb the registered outputs.
    task automatic t_hold();
        apply("R1 load", 3'd1, 1'b0, 16'sd3, 64'hA000_0000_0000_0000, 32'hA, 0, 0);
        @(negedge clk);
        in_class = 3'd2; in_sign = 1'b1; in_exp = 16'sd40; in_mant = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R1 hold", 32'hA, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_truncate();
        t_small();
        t_limits();
        t_big_exp();
        t_special();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule